// File: doc/BRIEF.md
# Signed Integer to Double-Precision Converter with Vector Merge

This unit takes a signed two's-complement integer, either 32 or 64 bits wide, and turns it into an IEEE-754 double-precision value. Inexact results are rounded in one of four directions chosen by a 2-bit control field. The double is placed in the low 64 bits of a wide vector register value, and the rest of that value is built according to one of two encoding forms.

The legacy form leaves every destination bit above bit 63 as it was. The three-operand form takes bits 127:64 from a separate first-source vector and clears everything above bit 127.

The conversion is combinational: absolute value, leading-one search, normalise, round, pack. The merged vector and an inexact flag are captured in one output register stage. As a result, each accepted request appears exactly one clock later. A 64-bit size request is honoured only while the long-mode input is high.

Top module: `i2f_dp_conv`

## Requirements
- R1: When `size64_i` and `long_mode_i` are both 1, all 64 bits of `src_i` are converted as a signed value.
- R2: Otherwise `src_i[31:0]` is converted as a signed 32-bit value and `src_i[63:32]` has no effect (`size64_i` is ignored when `long_mode_i` is 0). Such conversions are always exact, so `inexact_o` stays 0.
- R3: Bits 63:0 of `dest_o` hold the double: bit 63 is the sign, bits 62:52 are 1023 plus the bit index of the leading one of the magnitude, and bits 51:0 are the bits below that leading one.
- R4: With `vex_form_i` = 0 (legacy), `dest_o[VLEN-1:64]` equals `dest_i[VLEN-1:64]`.
- R5: With `vex_form_i` = 1 (three-operand), `dest_o[127:64]` equals `src1_i[127:64]` and `dest_o[VLEN-1:128]` is zero.
- R6: `rmode_i` = 2'b00 rounds to nearest, with ties going to an even fraction.
- R7: `rmode_i` = 2'b01 rounds toward negative infinity; 2'b10 rounds toward positive infinity.
- R8: `rmode_i` = 2'b11 truncates toward zero.
- R9: `inexact_o` is 1 exactly when any bit of the magnitude below the 53 kept bits is nonzero.
- R10: A zero input gives the all-zero encoding (+0.0) and `inexact_o` = 0.
- R11: The most negative input of either width converts exactly to -2^31 (0xC1E0000000000000) or -2^63 (0xC3E0000000000000).
- R12: A rounding increment that carries out of the fraction raises the exponent by one and gives a zero fraction.
- R13: Results appear one cycle after `valid_i`, with `valid_o` high for that one cycle. `dest_o` holds while `valid_i` is low, `inexact_o` is 0 when `valid_o` is 0, and reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| src_i | input | 64 | Integer source |
| size64_i | input | 1 | Request 64-bit operand |
| long_mode_i | input | 1 | 64-bit mode active; gates `size64_i` |
| vex_form_i | input | 1 | 0 legacy merge, 1 three-operand merge |
| rmode_i | input | 2 | Rounding control (00 nearest-even, 01 down, 10 up, 11 zero) |
| src1_i | input | 128 | First-source vector |
| dest_i | input | VLEN | Current destination contents |
| valid_o | output | 1 | Result strobe |
| dest_o | output | VLEN | Updated destination vector |
| inexact_o | output | 1 | Precision status for the result |

## Verification
The in-module assertions check, on every cycle, the properties that follow directly from the inputs:
- the one-cycle valid timing and the hold of `dest_o` while idle;
- both merge forms above bit 63;
- the exactness of every 32-bit conversion;
- the sign bit and the +0.0 output for a zero operand.

The numeric correctness of exponent and fraction, the rounding direction in each mode, tie-to-even and the fraction carry into the exponent can only be shown by the bench. It compares constrained-random and directed operands against an independently written reference conversion, including operands placed exactly on halfway points and at the largest positive and most negative values.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int unsigned INT_W  = 64;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned MANT_W = FRAC_W + 1;
  localparam int unsigned LEAD_W = $clog2(INT_W);
  localparam int unsigned DROP_W = INT_W - MANT_W;
  localparam logic [EXP_W-1:0] EXP_BIAS = 11'd1023;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/i2f_norm.sv
module i2f_norm
  import i2f_pkg::*;
(
  input  logic [INT_W-1:0]  op_i,
  output logic              sign_o,
  output logic              nonzero_o,
  output logic [LEAD_W-1:0] lead_o,
  output logic [INT_W-1:0]  norm_o
);
  logic [INT_W-1:0] mag;

  // unsigned negate: most negative value maps to 2^(INT_W-1) without overflow
  assign sign_o    = op_i[INT_W-1];
  assign mag       = sign_o ? (~op_i + 1'b1) : op_i;
  assign nonzero_o = |mag;

  always_comb begin
    lead_o = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lead_o = LEAD_W'(i);
    end
  end

  assign norm_o = mag << (LEAD_W'(INT_W - 1) - lead_o);
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
(
  input  logic              sign_i,
  input  logic              nonzero_i,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic [INT_W-1:0]  norm_i,
  input  logic [1:0]        rmode_i,
  output logic [63:0]       res_o,
  output logic              inexact_o
);
  logic              guard, sticky, lsb, inc, carry;
  logic [MANT_W:0]   mant_sum;
  logic [EXP_W-1:0]  exp_v;
  logic [FRAC_W-1:0] frac_v;

  assign guard  = norm_i[DROP_W-1];
  assign sticky = |norm_i[DROP_W-2:0];
  assign lsb    = norm_i[DROP_W];

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR: inc = guard & (sticky | lsb);
      RM_DOWN: inc = sign_i & (guard | sticky);
      RM_UP:   inc = ~sign_i & (guard | sticky);
      default: inc = 1'b0;
    endcase
  end

  assign mant_sum = {1'b0, norm_i[INT_W-1:DROP_W]} + (MANT_W+1)'(inc);
  assign carry    = mant_sum[MANT_W];
  assign frac_v   = carry ? '0 : mant_sum[FRAC_W-1:0];
  assign exp_v    = EXP_BIAS + EXP_W'(lead_i) + EXP_W'(carry);

  assign res_o     = nonzero_i ? {sign_i, exp_v, frac_v} : '0;
  assign inexact_o = nonzero_i & (guard | sticky);
endmodule

// File: rtl/i2f_merge.sv
module i2f_merge #(
  parameter int unsigned VLEN = 256
) (
  input  logic            vex_form_i,
  input  logic [63:0]     res_i,
  input  logic [127:0]    src1_i,
  input  logic [VLEN-1:0] dest_i,
  output logic [VLEN-1:0] merged_o
);
  logic [VLEN-1:0] legacy_v, vex_v;
  logic            unused_bits;

  assign legacy_v = {dest_i[VLEN-1:64], res_i};

  if (VLEN > 128) begin : g_wide
    assign vex_v = {{(VLEN-128){1'b0}}, src1_i[127:64], res_i};
  end else begin : g_narrow
    assign vex_v = {src1_i[127:64], res_i};
  end

  assign merged_o    = vex_form_i ? vex_v : legacy_v;
  assign unused_bits = ^{dest_i[63:0], src1_i[63:0]};
endmodule

// File: rtl/i2f_dp_conv.sv
module i2f_dp_conv
  import i2f_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [63:0]     src_i,
  input  logic            size64_i,
  input  logic            long_mode_i,
  input  logic            vex_form_i,
  input  logic [1:0]      rmode_i,
  input  logic [127:0]    src1_i,
  input  logic [VLEN-1:0] dest_i,
  output logic            valid_o,
  output logic [VLEN-1:0] dest_o,
  output logic            inexact_o
);
  logic              wide_sel;
  logic [INT_W-1:0]  op64;
  logic              sign, nonzero, inexact_c;
  logic [LEAD_W-1:0] lead;
  logic [INT_W-1:0]  norm;
  logic [63:0]       res;
  logic [VLEN-1:0]   merged;

  // 64-bit request honoured only in long mode
  assign wide_sel = size64_i & long_mode_i;
  assign op64     = wide_sel ? src_i : {{32{src_i[31]}}, src_i[31:0]};

  i2f_norm u_norm (
    .op_i      (op64),
    .sign_o    (sign),
    .nonzero_o (nonzero),
    .lead_o    (lead),
    .norm_o    (norm)
  );

  i2f_round u_round (
    .sign_i    (sign),
    .nonzero_i (nonzero),
    .lead_i    (lead),
    .norm_i    (norm),
    .rmode_i   (rmode_i),
    .res_o     (res),
    .inexact_o (inexact_c)
  );

  i2f_merge #(.VLEN(VLEN)) u_merge (
    .vex_form_i (vex_form_i),
    .res_i      (res),
    .src1_i     (src1_i),
    .dest_i     (dest_i),
    .merged_o   (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      dest_o    <= '0;
      inexact_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      inexact_o <= valid_i & inexact_c;
      if (valid_i) dest_o <= merged;
    end
  end

  a_r13_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r13_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !inexact_o));
  a_r13_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dest_o));
  a_r2_narrow_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(size64_i && long_mode_i)) |=> !inexact_o);
  a_r4_legacy_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !vex_form_i) |=> dest_o[VLEN-1:64] == $past(dest_i[VLEN-1:64]));
  a_r5_copy_src1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vex_form_i) |=> dest_o[127:64] == $past(src1_i[127:64]));
  if (VLEN > 128) begin : g_hi_chk
    a_r5_zero_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && vex_form_i) |=> dest_o[VLEN-1:128] == '0);
  end
  a_r10_zero_plus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op64 == '0) |=> (dest_o[63:0] == 64'd0 && !inexact_o));
  a_r3_sign_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op64 != '0) |=> dest_o[63] == $past(op64[63]));
endmodule

// File: tb/i2f_dp_conv_tb.sv
`timescale 1ns/1ps
module i2f_dp_conv_tb_top;
  localparam int unsigned VLEN = 256;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [63:0]     src_i = '0;
  logic            size64_i = 1'b0, long_mode_i = 1'b0, vex_form_i = 1'b0;
  logic [1:0]      rmode_i = '0;
  logic [127:0]    src1_i = '0;
  logic [VLEN-1:0] dest_i = '0;
  logic            valid_o, inexact_o;
  logic [VLEN-1:0] dest_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2f_dp_conv #(.VLEN(VLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .size64_i(size64_i), .long_mode_i(long_mode_i), .vex_form_i(vex_form_i),
    .rmode_i(rmode_i), .src1_i(src1_i), .dest_i(dest_i),
    .valid_o(valid_o), .dest_o(dest_o), .inexact_o(inexact_o)
  );

  // reference: shift right until 53 bits remain, tracking guard and sticky
  function automatic logic [64:0] ref_conv(input logic [63:0] op, input logic [1:0] rm);
    logic neg, g, s, inc;
    logic [63:0] m;
    int e;
    if (op == 64'd0) return 65'd0;
    neg = op[63];
    m = neg ? (~op + 64'd1) : op;
    e = 1023 + 52; g = 0; s = 0;
    while (m[63:53] != 0) begin s = s | g; g = m[0]; m = m >> 1; e++; end
    while (!m[52]) begin m = m << 1; e--; end
    case (rm)
      2'b00:   inc = g & (s | m[0]);
      2'b01:   inc = neg & (g | s);
      2'b10:   inc = !neg & (g | s);
      default: inc = 1'b0;
    endcase
    m = m + 64'(inc);
    if (m[53]) begin m = m >> 1; e++; end
    return {g | s, neg, 11'(e), m[51:0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [63:0] s, input logic s64,
                     input logic lm, input logic vex, input logic [1:0] rm,
                     input logic [127:0] s1, input logic [VLEN-1:0] d);
    logic [63:0] op;
    logic [64:0] r;
    logic [VLEN-1:0] exp_d;
    op = (s64 && lm) ? s : {{32{s[31]}}, s[31:0]};
    r = ref_conv(op, rm);
    exp_d = vex ? {{(VLEN-128){1'b0}}, s1[127:64], r[63:0]} : {d[VLEN-1:64], r[63:0]};
    @(negedge clk);
    valid_i = 1; src_i = s; size64_i = s64; long_mode_i = lm;
    vex_form_i = vex; rmode_i = rm; src1_i = s1; dest_i = d;
    @(negedge clk);
    check(req, "dest", dest_o, exp_d);
    check(req, "inexact", VLEN'(inexact_o), VLEN'(r[64]));
    check("R13", "valid", VLEN'(valid_o), VLEN'(1));
    valid_i = 0;
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [VLEN-1:0] held;
    logic [63:0] s;
    void'($urandom(32'h5eed_1f2d));
    repeat (3) @(negedge clk);
    check("R13", "reset dest", dest_o, '0);
    check("R13", "reset flags", VLEN'({valid_o, inexact_o}), '0);
    rst_ni = 1;

    // R1 / R2 operand selection
    run("R1", 64'h0000_0001_0000_0000, 1, 1, 0, 2'b00, '1, rnd_vec());
    run("R2", 64'hFFFF_FFFF_0000_0005, 1, 0, 0, 2'b00, '1, rnd_vec());
    run("R2", 64'h1234_5678_FFFF_FFFF, 0, 1, 1, 2'b01, rnd_vec(), rnd_vec());
    // R10 zero
    run("R10", 64'hABCD_0000_0000_0000, 0, 1, 0, 2'b10, '0, rnd_vec());
    // R11 most negative
    run("R11", 64'h0000_0000_8000_0000, 0, 1, 0, 2'b00, '0, rnd_vec());
    run("R11", 64'h8000_0000_0000_0000, 1, 1, 1, 2'b11, rnd_vec(), rnd_vec());
    // R6 ties: 2^53+1 ties down to even, 2^53+3 ties up
    run("R6", 64'h0020_0000_0000_0001, 1, 1, 0, 2'b00, '0, '0);
    run("R6", 64'h0020_0000_0000_0003, 1, 1, 0, 2'b00, '0, '0);
    // R7 directed rounding on negative and positive inexact
    run("R7", -64'sd9007199254740993, 1, 1, 0, 2'b01, '0, '0);
    run("R7", -64'sd9007199254740993, 1, 1, 0, 2'b10, '0, '0);
    run("R7", 64'h0020_0000_0000_0001, 1, 1, 0, 2'b10, '0, '0);
    // R8 truncation; R12 carry out on largest positive
    run("R8", 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 0, 2'b11, '0, '0);
    run("R12", 64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 0, 2'b00, '0, '0);
    check("R12", "carry encoding", dest_o[63:0], 64'h43E0_0000_0000_0000);
    // R4 / R5 merges
    run("R4", 64'd7, 0, 0, 0, 2'b00, rnd_vec(), rnd_vec());
    run("R5", 64'd7, 0, 0, 1, 2'b00, rnd_vec(), '1);
    // R13 hold while idle
    held = dest_o;
    @(negedge clk); dest_i = rnd_vec(); src_i = 64'h55;
    @(negedge clk);
    check("R13", "idle hold", dest_o, held);
    check("R13", "idle flags", VLEN'({valid_o, inexact_o}), '0);

    // random sweep, R9 inexact flag over all widths and modes
    for (int k = 0; k < 3000; k++) begin
      s = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 2) s = -s;
      run((k % 2) ? "R9" : "R3", s, 1'($urandom), 1'($urandom), 1'($urandom),
          2'($urandom), rnd_vec(), rnd_vec());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule